// File: doc/BRIEF.md
# Network Controller Interrupt Status Register

This block holds the interrupt status word of a network controller. Software reaches it through a simple register port at offset 0x008. Single-cycle event pulses from the MAC, the transmit and receive paths and the transmit data FIFO are caught in sticky bits. Software clears a sticky bit by writing 1 to it. The PHY interrupt is a level that the register shows as it is, and software cannot clear it. Eleven GPIO interrupt levels are latched into write-one-to-clear bits. Clearing a GPIO bit also sends a one-cycle clear pulse to that GPIO's wake-event logic.

Interrupt enable masking and the combined interrupt line live downstream. This block only gives them a summary output, `irq_pending`, which is high while any status bit reads 1. The block has no state machine. The two sticky banks are plain registers, and a parameter sets which of set or clear has priority in each bank: set has priority for event bits, and clear has priority for GPIO bits.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, every status bit is 0 and `gpio_wake_clr` is 0.
- R2: A one-cycle pulse on `ev_mac_timeout`, `ev_tx_stopped`, `ev_rx_stopped`, `ev_tx_error`, `ev_txf_underrun` or `ev_rx_dropped` sets bit 18, 17, 16, 14, 13 or 11, in that order. The bit stays at 1 after the pulse ends.
- R3: Bit 12 (FIFO overrun) is set in a cycle where `txf_full` and `txf_wr_try` are both high. Either signal alone does not set it.
- R4: A write of 1 to a sticky bit clears it at the write edge. A write of 0 leaves it unchanged.
- R5: If an event pulse and a write of 1 to the same bit fall in the same cycle, the bit ends up 1.
- R6: Bit 15 reads the current value of `phy_irq`. Writes to bit 15 have no effect.
- R7: A high level on `gpio_irq[i]` sets bit i (i from 0 to 10), and the bit stays set after the level falls. A write of 1 to the bit clears it for at least one cycle, even while the level is still high. If the level is still high, the bit is set again on the next cycle.
- R8: A write with data bit i = 1 (i from 0 to 10) drives `gpio_wake_clr[i]` high for exactly the one cycle after the write edge. The pulse does not depend on the bit's current state.
- R9: Bits 31:19 always read 0. Writes to them have no effect.
- R10: A read or write only takes effect when `reg_addr` equals 0x008. At any other address, a write changes no bit and gives no wake pulse, and `reg_rdata` reads 0. `reg_rdata` also reads 0 when `reg_rd` is low.
- R11: `irq_pending` is high exactly when at least one of bits 18:0 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data, where a 1 clears the bit |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, 0 unless a read is selected |
| ev_mac_timeout | input | 1 | MAC reset watchdog timeout pulse |
| ev_tx_stopped | input | 1 | Transmitter halted pulse |
| ev_rx_stopped | input | 1 | Receiver halted pulse |
| ev_tx_error | input | 1 | Transmitter error pulse |
| ev_txf_underrun | input | 1 | TX data FIFO underrun pulse |
| txf_full | input | 1 | TX data FIFO full |
| txf_wr_try | input | 1 | Write attempted into the TX data FIFO |
| ev_rx_dropped | input | 1 | Receive frame dropped pulse |
| phy_irq | input | 1 | PHY interrupt level |
| gpio_irq | input | 11 | GPIO interrupt levels |
| gpio_wake_clr | output | 11 | One-cycle wake-event clear pulses |
| irq_pending | output | 1 | Any status bit set |

## Verification
Each sticky bit shows its internal state at the read port in the same cycle as the read. So a bit that fails to latch, or that is cleared when it should not be, reads wrong at the first read after the edge that caused it. The bench does such a read right after each pulse, clear and collision. A wrong priority between set and clear shows at the first read after the colliding edge. A stray or missing wake pulse shows on `gpio_wake_clr` one cycle after the write. The GPIO re-set appears at the second read after a clear while the level is still high.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int REG_W    = 32;
    localparam int USED_W   = 19;
    localparam int GPIO_N   = 11;
    localparam int EV_N     = 7;
    localparam int B_RXDROP = 11;
    localparam int B_OVR    = 12;
    localparam int B_UND    = 13;
    localparam int B_TXERR  = 14;
    localparam int B_PHY    = 15;
    localparam int B_RXSTOP = 16;
    localparam int B_TXSTOP = 17;
    localparam int B_MACTO  = 18;

    typedef enum logic {
        MODE_SET_WINS = 1'b0,
        MODE_CLR_WINS = 1'b1
    } sticky_mode_e;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank
    import irq_agg_pkg::*;
#(
    parameter int           W    = 7,
    parameter sticky_mode_e MODE = MODE_SET_WINS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;
    logic [W-1:0] q_nxt;

    generate
        if (MODE == MODE_SET_WINS) begin : g_set_wins
            assign q_nxt = (q_r & ~clr_i) | set_i;

            // R5: a set in the same cycle as a clear leaves the bit at 1
            p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (set_i != '0) |=> ((q_r & $past(set_i)) == $past(set_i)));

            // R4: a clear with no set drops the bit
            p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ((clr_i & ~set_i) != '0) |=> ((q_r & $past(clr_i & ~set_i)) == '0));
        end else begin : g_clr_wins
            assign q_nxt = (q_r | set_i) & ~clr_i;

            // R7: a clear takes priority even while the level is high
            p_clr_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i != '0) |=> ((q_r & $past(clr_i)) == '0));

            // R7: a level with no clear is latched
            p_level_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
                ((set_i & ~clr_i) != '0) |=> ((q_r & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
    end

    assign q_o = q_r;

    // R2: a bit never rises without a set in the cycle before
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q_r & ~$past(q_r) & ~$past(set_i)) == '0));
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_agg_pkg::*;
#(
    parameter int              ADDR_W = 12,
    parameter logic [ADDR_W-1:0] OFFSET = 'h008
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [USED_W-1:0] status_i,
    output logic [USED_W-1:0] wr_clr_o,
    output logic [REG_W-1:0]  rdata_o
);
    localparam int RSV_W = REG_W - USED_W;

    logic sel;
    logic unused_rsv_wdata;

    assign sel              = (reg_addr == OFFSET);
    assign unused_rsv_wdata = ^reg_wdata[REG_W-1:USED_W];

    always_comb begin
        wr_clr_o = '0;
        rdata_o  = '0;
        if (reg_wr && sel) wr_clr_o = reg_wdata[USED_W-1:0];
        if (reg_rd && sel) rdata_o  = {{RSV_W{1'b0}}, status_i};
    end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_rd,
    output logic [31:0]       reg_rdata,
    input  logic              ev_mac_timeout,
    input  logic              ev_tx_stopped,
    input  logic              ev_rx_stopped,
    input  logic              ev_tx_error,
    input  logic              ev_txf_underrun,
    input  logic              txf_full,
    input  logic              txf_wr_try,
    input  logic              ev_rx_dropped,
    input  logic              phy_irq,
    input  logic [10:0]       gpio_irq,
    output logic [10:0]       gpio_wake_clr,
    output logic              irq_pending
);
    logic [USED_W-1:0] wr_clr;
    logic [USED_W-1:0] status;
    logic [EV_N-1:0]   ev_set;
    logic [EV_N-1:0]   ev_clr;
    logic [EV_N-1:0]   ev_q;
    logic [GPIO_N-1:0] gpio_q;
    logic [GPIO_N-1:0] wake_r;
    logic              txf_overrun;
    logic              unused_phy_wr;

    assign txf_overrun   = txf_full & txf_wr_try;
    assign unused_phy_wr = wr_clr[B_PHY];

    // event bank order: 6 macto, 5 txstop, 4 rxstop, 3 txerr, 2 und, 1 ovr, 0 rxdrop
    assign ev_set = {ev_mac_timeout, ev_tx_stopped, ev_rx_stopped,
                     ev_tx_error, ev_txf_underrun, txf_overrun, ev_rx_dropped};
    assign ev_clr = {wr_clr[B_MACTO:B_RXSTOP], wr_clr[B_TXERR:B_RXDROP]};

    irq_sticky_bank #(.W(EV_N), .MODE(MODE_SET_WINS)) u_ev_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ev_set),
        .clr_i (ev_clr),
        .q_o   (ev_q)
    );

    irq_sticky_bank #(.W(GPIO_N), .MODE(MODE_CLR_WINS)) u_gpio_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (gpio_irq),
        .clr_i (wr_clr[GPIO_N-1:0]),
        .q_o   (gpio_q)
    );

    assign status = {ev_q[6:4], phy_irq, ev_q[3:0], gpio_q};

    irq_reg_port #(.ADDR_W(ADDR_W), .OFFSET(REG_OFFSET)) u_port (
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .status_i  (status),
        .wr_clr_o  (wr_clr),
        .rdata_o   (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) wake_r <= '0;
        else        wake_r <= wr_clr[GPIO_N-1:0];
    end

    assign gpio_wake_clr = wake_r;
    assign irq_pending   = |status;

    // R8: a selected write yields its GPIO data bits as the wake pulse next cycle
    p_wake_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_OFFSET) |=> (gpio_wake_clr == $past(reg_wdata[10:0])));

    // R10: no selected write, no wake pulse
    p_wake_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == REG_OFFSET) |=> (gpio_wake_clr == '0));

    // R6: the PHY bit on the read port tracks the level
    p_phy_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == REG_OFFSET) |-> (reg_rdata[B_PHY] == phy_irq));

    // R11: the PHY level alone raises the summary
    p_pending_phy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        phy_irq |-> irq_pending);

    // R3: full plus write attempt is seen at the next read
    p_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (txf_full && txf_wr_try) |=> irq_pending);
endmodule

// File: tb/tb_irq_status_agg.sv
module tb_irq_status_agg;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] OFS = 12'h008;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = OFS;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        ev_mac_timeout = 0, ev_tx_stopped = 0, ev_rx_stopped = 0;
    logic        ev_tx_error = 0, ev_txf_underrun = 0, ev_rx_dropped = 0;
    logic        txf_full = 0, txf_wr_try = 0, phy_irq = 0;
    logic [10:0] gpio_irq = '0;
    logic [10:0] gpio_wake_clr;
    logic        irq_pending;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_agg dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .ev_mac_timeout(ev_mac_timeout), .ev_tx_stopped(ev_tx_stopped),
        .ev_rx_stopped(ev_rx_stopped), .ev_tx_error(ev_tx_error),
        .ev_txf_underrun(ev_txf_underrun), .txf_full(txf_full),
        .txf_wr_try(txf_wr_try), .ev_rx_dropped(ev_rx_dropped),
        .phy_irq(phy_irq), .gpio_irq(gpio_irq),
        .gpio_wake_clr(gpio_wake_clr), .irq_pending(irq_pending)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // read at the current negedge, combinational result
    task automatic rd_reg(input logic [11:0] a, output logic [31:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        reg_rd = 1'b0; reg_addr = OFS;
    endtask

    // write spans one posedge; returns the wake pulse seen after it
    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d, output logic [10:0] wk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; reg_addr = OFS;
        wk = gpio_wake_clr;
    endtask

    task automatic drive_ev(input int k, input logic v);
        case (k)
            0: ev_mac_timeout  = v;
            1: ev_tx_stopped   = v;
            2: ev_rx_stopped   = v;
            3: ev_tx_error     = v;
            4: ev_txf_underrun = v;
            default: ev_rx_dropped = v;
        endcase
    endtask

    function automatic int ev_bit(input int k);
        case (k)
            0: return 18;
            1: return 17;
            2: return 16;
            3: return 14;
            4: return 13;
            default: return 11;
        endcase
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd_reg(OFS, v);
        check(v == 32'h0, "R1 reset status", v, 32'h0);
        check(gpio_wake_clr == '0, "R1 reset wake", {21'b0, gpio_wake_clr}, 32'h0);
        check(irq_pending == 1'b0, "R11 idle pending", {31'b0, irq_pending}, 32'h0);
    endtask

    task automatic t_events();
        logic [31:0] v;
        logic [10:0] wk;
        for (int k = 0; k < 6; k++) begin
            drive_ev(k, 1'b1);
            @(negedge clk);
            drive_ev(k, 1'b0);
            @(negedge clk);
            rd_reg(OFS, v);
            check(v == (32'h1 << ev_bit(k)), "R2 pulse latched", v, 32'h1 << ev_bit(k));
            check(irq_pending, "R11 pending on event", {31'b0, irq_pending}, 32'h1);
            wr_reg(OFS, ~(32'h1 << ev_bit(k)) & 32'h0007_F800, wk);
            rd_reg(OFS, v);
            check(v == (32'h1 << ev_bit(k)), "R4 write zero keeps bit", v, 32'h1 << ev_bit(k));
            wr_reg(OFS, 32'h1 << ev_bit(k), wk);
            rd_reg(OFS, v);
            check(v == 32'h0, "R4 write one clears", v, 32'h0);
            check(!irq_pending, "R11 pending drops", {31'b0, irq_pending}, 32'h0);
        end
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        txf_full = 1'b1;
        @(negedge clk);
        txf_full = 1'b0; txf_wr_try = 1'b1;
        @(negedge clk);
        txf_wr_try = 1'b0;
        rd_reg(OFS, v);
        check(v == 32'h0, "R3 single condition no overrun", v, 32'h0);
        txf_full = 1'b1; txf_wr_try = 1'b1;
        @(negedge clk);
        txf_full = 1'b0; txf_wr_try = 1'b0;
        rd_reg(OFS, v);
        check(v == 32'h0000_1000, "R3 overrun latched", v, 32'h0000_1000);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        logic [10:0] wk;
        ev_tx_error = 1'b1;
        wr_reg(OFS, 32'h0000_5000, wk);
        ev_tx_error = 1'b0;
        rd_reg(OFS, v);
        check(v == 32'h0000_4000, "R5 set beats clear", v, 32'h0000_4000);
        wr_reg(OFS, 32'h0000_4000, wk);
        rd_reg(OFS, v);
        check(v == 32'h0, "R4 cleared after collision", v, 32'h0);
    endtask

    task automatic t_phy();
        logic [31:0] v;
        logic [10:0] wk;
        phy_irq = 1'b1;
        #1;
        check(irq_pending, "R11 pending from phy", {31'b0, irq_pending}, 32'h1);
        rd_reg(OFS, v);
        check(v == 32'h0000_8000, "R6 phy level shown", v, 32'h0000_8000);
        wr_reg(OFS, 32'h0000_8000, wk);
        rd_reg(OFS, v);
        check(v == 32'h0000_8000, "R6 write ignored", v, 32'h0000_8000);
        phy_irq = 1'b0;
        rd_reg(OFS, v);
        check(v == 32'h0, "R6 phy level gone", v, 32'h0);
    endtask

    task automatic t_gpio();
        logic [31:0] v;
        logic [10:0] wk;
        gpio_irq = 11'h008;
        @(negedge clk);
        gpio_irq = '0;
        @(negedge clk);
        rd_reg(OFS, v);
        check(v == 32'h0000_0008, "R7 level latched", v, 32'h8);
        wr_reg(OFS, 32'h0000_0008, wk);
        check(wk == 11'h008, "R8 wake pulse", {21'b0, wk}, 32'h8);
        rd_reg(OFS, v);
        check(v == 32'h0, "R7 gpio cleared", v, 32'h0);
        @(negedge clk);
        check(gpio_wake_clr == '0, "R8 pulse one cycle", {21'b0, gpio_wake_clr}, 32'h0);
        wr_reg(OFS, 32'h0000_0401, wk);
        check(wk == 11'h401, "R8 pulse on clear bits", {21'b0, wk}, 32'h401);
        gpio_irq = 11'h400;
        @(negedge clk);
        wr_reg(OFS, 32'h0000_0400, wk);
        rd_reg(OFS, v);
        check(v == 32'h0, "R7 clear beats held level", v, 32'h0);
        @(negedge clk);
        rd_reg(OFS, v);
        check(v == 32'h0000_0400, "R7 re-set while held", v, 32'h400);
        gpio_irq = '0;
        wr_reg(OFS, 32'h0000_0400, wk);
    endtask

    task automatic t_reserved_and_offset();
        logic [31:0] v;
        logic [10:0] wk;
        ev_rx_dropped = 1'b1; gpio_irq = 11'h002;
        @(negedge clk);
        ev_rx_dropped = 1'b0; gpio_irq = '0;
        wr_reg(12'h00C, 32'hFFFF_FFFF, wk);
        check(wk == '0, "R10 other offset no wake", {21'b0, wk}, 32'h0);
        rd_reg(OFS, v);
        check(v == 32'h0000_0802, "R10 other offset no clear", v, 32'h802);
        rd_reg(12'h004, v);
        check(v == 32'h0, "R10 other offset reads zero", v, 32'h0);
        #1;
        check(reg_rdata == 32'h0, "R10 idle rdata zero", reg_rdata, 32'h0);
        wr_reg(OFS, 32'hFFF8_0000, wk);
        rd_reg(OFS, v);
        check(v == 32'h0000_0802, "R9 reserved write ignored", v, 32'h802);
        wr_reg(OFS, 32'hFFFF_FFFF, wk);
        rd_reg(OFS, v);
        check(v[31:19] == '0, "R9 reserved read zero", v, 32'h0);
        check(v == 32'h0, "R4 clear all", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_overrun();
        t_set_wins();
        t_phy();
        t_gpio();
        t_reserved_and_offset();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule